// File: doc/BRIEF.md
# Cascadable 4-Bit Magnitude Comparator

This block is a purely combinational cell. It compares two 4-bit words, A and B, where bit 3 carries the most weight. It drives three relation outputs: A greater, A less and A equal. The cell also takes three cascade inputs that carry the relation already found by a less significant cell. Wider words are built by chaining cells: each cell's three outputs go one-to-one into the cascade inputs of the next more significant cell. The least significant cell has its cascade inputs tied to greater=0, less=0, equal=1.

The decision is made from the most significant unequal bit pair downward. The cell therefore gives correct results for any monotonic code, binary or BCD alike. When the two words match, the cascade inputs decide the outputs. This mapping is defined for every cascade combination, including the contradictory ones: both greater and less high resolves to "neither", and all three low resolves to "both". This lets a downstream cell treat such a result as information about an extra bit.

Top module: `mag_cmp_cell`

## Requirements
- R1: When the words differ and the most significant unequal bit pair has A's bit at 1, the outputs are greater=1, less=0, equal=0.
- R2: When the words differ and the most significant unequal bit pair has A's bit at 0, the outputs are greater=0, less=1, equal=0.
- R3: When the words differ, neither the bits below the most significant unequal pair nor the three cascade inputs affect any output.
- R4: When the words match and the equal cascade input is 1, the outputs are greater=0, less=0, equal=1, whatever the other two cascade inputs are.
- R5: When the words match and the cascade inputs are (greater,less,equal)=(1,0,0), the outputs are (1,0,0). With cascade inputs (0,1,0), the outputs are (0,1,0).
- R6: When the words match and the cascade inputs are (1,1,0), all three outputs are 0.
- R7: When the words match and all three cascade inputs are 0, the outputs are greater=1, less=1, equal=0.
- R8: The equal output is 1 exactly when the words match and the equal cascade input is 1.
- R9: Two cells chained in series, the lower one tied to (0,0,1), produce the correct relation of two 8-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | 4 | Word A, bit 3 most significant |
| b_word | input | 4 | Word B, bit 3 most significant |
| casc_gt_i | input | 1 | Cascade input: lower part found A greater |
| casc_lt_i | input | 1 | Cascade input: lower part found A less |
| casc_eq_i | input | 1 | Cascade input: lower part found equal |
| a_gt_b_o | output | 1 | A greater than B |
| a_lt_b_o | output | 1 | A less than B |
| a_eq_b_o | output | 1 | A equal to B |

## Verification
A table of directed vectors comes first. It places the deciding bit pair at the top and at the bottom of the word, and pairs each of the four contradictory or legal cascade settings with equal words. This separates a mistake in bit priority from a mistake in the cascade mapping. A sweep of all 2048 combinations of the two words and the cascade inputs is then checked against a reference built on integer comparison. For R3, the top bits are held unequal while the lower bits and the cascade inputs are varied, which exposes any leak from below the deciding pair. An exhaustive sweep of two chained cells over all 8-bit word pairs confirms that the outputs of one cell mean the right thing as cascade inputs of the next.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;
    // Relation triple shared by the slices, the cascade path and the outputs.
    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } rel_t;
endpackage

// File: rtl/mag_bit_slice.sv
module mag_bit_slice
    import magcmp_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    output rel_t rel_d
);
    always_comb begin
        rel_d.gt = a_bit & ~b_bit;
        rel_d.lt = ~a_bit & b_bit;
        rel_d.eq = ~(a_bit ^ b_bit);
    end
endmodule

// File: rtl/mag_msb_resolver.sv
module mag_msb_resolver
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  rel_t [WIDTH-1:0] slice_i,
    output logic             decided_d,
    output logic             a_wins_d
);
    // Scan from the top slice down; the first unequal slice settles the result.
    always_comb begin
        decided_d = 1'b0;
        a_wins_d  = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (!decided_d && !slice_i[i].eq) begin
                decided_d = 1'b1;
                a_wins_d  = slice_i[i].gt & ~slice_i[i].lt;
            end
        end
    end
endmodule

// File: rtl/mag_cascade_map.sv
module mag_cascade_map
    import magcmp_pkg::*;
(
    input  rel_t casc_i,
    output rel_t map_d
);
    // Equal in -> equal out; otherwise each output is set unless the
    // opposite cascade input is high (both high -> none, none -> both).
    always_comb begin
        map_d.eq = casc_i.eq;
        map_d.gt = ~casc_i.eq & ~casc_i.lt;
        map_d.lt = ~casc_i.eq & ~casc_i.gt;
    end
endmodule

// File: rtl/mag_cmp_cell.sv
module mag_cmp_cell
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    input  logic             casc_gt_i,
    input  logic             casc_lt_i,
    input  logic             casc_eq_i,
    output logic             a_gt_b_o,
    output logic             a_lt_b_o,
    output logic             a_eq_b_o
);
    rel_t [WIDTH-1:0] slice_d;
    logic             decided_d;
    logic             a_wins_d;
    rel_t             casc_d;
    rel_t             map_d;
    rel_t             out_d;

    for (genvar g = 0; g < WIDTH; g++) begin : g_slice
        mag_bit_slice u_slice (
            .a_bit (a_word[g]),
            .b_bit (b_word[g]),
            .rel_d (slice_d[g])
        );
    end

    mag_msb_resolver #(.WIDTH(WIDTH)) u_resolve (
        .slice_i   (slice_d),
        .decided_d (decided_d),
        .a_wins_d  (a_wins_d)
    );

    always_comb begin
        casc_d.gt = casc_gt_i;
        casc_d.lt = casc_lt_i;
        casc_d.eq = casc_eq_i;
    end

    mag_cascade_map u_map (
        .casc_i (casc_d),
        .map_d  (map_d)
    );

    always_comb begin
        if (decided_d) begin
            out_d.gt = a_wins_d;
            out_d.lt = ~a_wins_d;
            out_d.eq = 1'b0;
        end else begin
            out_d = map_d;
        end
    end

    assign a_gt_b_o = out_d.gt;
    assign a_lt_b_o = out_d.lt;
    assign a_eq_b_o = out_d.eq;
endmodule

// File: rtl/mag_cmp_cell_chk.sv
module mag_cmp_cell_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_word,
    input logic [WIDTH-1:0] b_word,
    input logic             casc_gt_i,
    input logic             casc_lt_i,
    input logic             casc_eq_i,
    input logic             a_gt_b_o,
    input logic             a_lt_b_o,
    input logic             a_eq_b_o
);
    logic same_w;
    assign same_w = (a_word == b_word);

    always_comb begin
        if (!$isunknown({a_word, b_word, casc_gt_i, casc_lt_i, casc_eq_i})) begin
            p_a_above_r1: assert (!(a_word > b_word) || (a_gt_b_o && !a_lt_b_o && !a_eq_b_o))
                else $error("r1: A above B gave wrong outputs");
            p_a_below_r2: assert (!(a_word < b_word) || (!a_gt_b_o && a_lt_b_o && !a_eq_b_o))
                else $error("r2: A below B gave wrong outputs");
            p_eq_casc_r4: assert (!(same_w && casc_eq_i) || (!a_gt_b_o && !a_lt_b_o && a_eq_b_o))
                else $error("r4: equal cascade not passed through");
            p_both_high_r6: assert (!(same_w && casc_gt_i && casc_lt_i && !casc_eq_i)
                                    || {a_gt_b_o, a_lt_b_o, a_eq_b_o} == 3'b000)
                else $error("r6: contradictory cascade mapping wrong");
            p_all_low_r7: assert (!(same_w && !casc_gt_i && !casc_lt_i && !casc_eq_i)
                                  || {a_gt_b_o, a_lt_b_o, a_eq_b_o} == 3'b110)
                else $error("r7: empty cascade mapping wrong");
            p_eq_iff_r8: assert (a_eq_b_o == (same_w && casc_eq_i))
                else $error("r8: equal output mismatch");
        end
    end
endmodule

bind mag_cmp_cell mag_cmp_cell_chk #(.WIDTH(WIDTH)) i_chk (
    .a_word    (a_word),
    .b_word    (b_word),
    .casc_gt_i (casc_gt_i),
    .casc_lt_i (casc_lt_i),
    .casc_eq_i (casc_eq_i),
    .a_gt_b_o  (a_gt_b_o),
    .a_lt_b_o  (a_lt_b_o),
    .a_eq_b_o  (a_eq_b_o)
);

// File: tb/test_mag_cmp_cell.sv
module test_mag_cmp_cell;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    logic [3:0] a, b;
    logic       cg, cl, ce;
    logic       og, ol, oe;

    mag_cmp_cell i_mag_cmp_cell (
        .a_word(a), .b_word(b),
        .casc_gt_i(cg), .casc_lt_i(cl), .casc_eq_i(ce),
        .a_gt_b_o(og), .a_lt_b_o(ol), .a_eq_b_o(oe)
    );

    // Two-cell chain for R9: lower cell tied to (0,0,1).
    logic [7:0] wa, wb;
    logic       lg, ll, le, hg, hl, he;

    mag_cmp_cell i_mag_cmp_cell_lo (
        .a_word(wa[3:0]), .b_word(wb[3:0]),
        .casc_gt_i(1'b0), .casc_lt_i(1'b0), .casc_eq_i(1'b1),
        .a_gt_b_o(lg), .a_lt_b_o(ll), .a_eq_b_o(le)
    );
    mag_cmp_cell i_mag_cmp_cell_hi (
        .a_word(wa[7:4]), .b_word(wb[7:4]),
        .casc_gt_i(lg), .casc_lt_i(ll), .casc_eq_i(le),
        .a_gt_b_o(hg), .a_lt_b_o(hl), .a_eq_b_o(he)
    );

    typedef struct packed {
        logic [3:0] va;
        logic [3:0] vb;
        logic [2:0] cin;   // {gt,lt,eq}
        logic [2:0] exp;   // {gt,lt,eq}
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t TBL [NVEC] = '{
        '{4'd8,  4'd7,  3'b110, 3'b100, 4'd1},  // R1 decided at bit 3
        '{4'd3,  4'd2,  3'b001, 3'b100, 4'd1},  // R1 decided at bit 0
        '{4'd4,  4'd5,  3'b001, 3'b010, 4'd2},  // R2 decided at bit 0
        '{4'd0,  4'd15, 3'b100, 3'b010, 4'd2},  // R2 decided at bit 3
        '{4'd9,  4'd1,  3'b010, 3'b100, 4'd3},  // R3 cascade ignored
        '{4'd6,  4'd6,  3'b111, 3'b001, 4'd4},  // R4
        '{4'd6,  4'd6,  3'b101, 3'b001, 4'd4},  // R4
        '{4'd10, 4'd10, 3'b100, 3'b100, 4'd5},  // R5
        '{4'd10, 4'd10, 3'b010, 3'b010, 4'd5},  // R5
        '{4'd15, 4'd15, 3'b110, 3'b000, 4'd6},  // R6
        '{4'd0,  4'd0,  3'b000, 3'b110, 4'd7}   // R7
    };

    function automatic logic [2:0] ref_rel(input logic [3:0] x, input logic [3:0] y,
                                           input logic [2:0] c);
        if (x > y) return 3'b100;
        if (x < y) return 3'b010;
        if (c[0])  return 3'b001;
        return {~c[1], ~c[2], 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: a=%0d b=%0d cin=%b actual=%b expected=%b", tag, a, b,
                     {cg, cl, ce}, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] x, input logic [3:0] y, input logic [2:0] c);
        @(negedge clk);
        a = x; b = y; {cg, cl, ce} = c;
        #2;
    endtask

    initial begin
        a = '0; b = '0; {cg, cl, ce} = 3'b001; wa = '0; wb = '0;
        #3;
        // Idle state with the standard least-significant tie: equal.
        chk("R4 idle tie", {og, ol, oe}, 3'b001);

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].va, TBL[i].vb, TBL[i].cin);
            chk($sformatf("R%0d table[%0d]", TBL[i].req, i), {og, ol, oe}, TBL[i].exp);
        end

        // R3: top bit fixed unequal, lower bits and cascade swept.
        for (int k = 0; k < 512; k++) begin
            drive({1'b1, k[2:0]}, {1'b0, k[5:3]}, k[8:6]);
            chk("R3 lower bits ignored", {og, ol, oe}, 3'b100);
        end

        // R1 R2 R4 R5 R6 R7 R8: exhaustive sweep.
        for (int k = 0; k < 2048; k++) begin
            drive(k[3:0], k[7:4], k[10:8]);
            chk("R8 sweep", {og, ol, oe}, ref_rel(k[3:0], k[7:4], k[10:8]));
        end

        // R9: chained 8-bit compare.
        for (int k = 0; k < 65536; k++) begin
            @(negedge clk);
            wa = k[7:0]; wb = k[15:8];
            #2;
            total++;
            if ({hg, hl, he} !== ((wa > wb) ? 3'b100 : (wa < wb) ? 3'b010 : 3'b001)) begin
                bad++;
                $display("FAIL R9 chain: wa=%0d wb=%0d actual=%b", wa, wb, {hg, hl, he});
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule